// File: doc/BRIEF.md
# TDM Backplane Slot Multiplexer (Transmit)

This block builds the transmit side of a serial time-division backplane. The line carries 64 eight-bit timeslots per frame at 4.096 Mbps. Two channelised streams, A and B, each wait in a first-word-fall-through byte FIFO outside the block. A 64-entry slot map gives each timeslot one of three roles: it stays unassigned, it carries the next byte of stream A, or it carries the next byte of stream B. Unassigned slots carry a programmable idle byte. No FIFO is ever read for an unassigned slot.

Software fills the slot map one entry at a time through a write port. The entries land in a shadow copy, and the whole shadow copy moves into the live map at the frame boundary. A new layout therefore never tears a frame. The same hardware supports several layouts:
- T1 streams interleaved byte by byte;
- T1 streams placed one whole frame after the other;
- E1 streams that simply alternate.

The block also drives the frame pulse. When a FIFO runs dry in its slot, the block sends the idle byte instead and sets a sticky underrun flag for that stream.

Top module: `tdm_slot_mux`

## Requirements
- R1: After reset, frame_pulse is 1, tx_bit is 1, both read strobes are 0 and both underrun flags are 0. Both the shadow map and the live map hold all-unassigned entries.
- R2: All state advances only in a cycle with bit_en high. With bit_en low, tx_bit and frame_pulse hold their values.
- R3: Each timeslot takes 8 bit_en periods, and its byte goes out MSB first. The block counts 64 timeslots per frame, numbered 0 to 63.
- R4: Map code 2'b00, and also 2'b11, marks a slot unassigned. The slot sends idle_byte as sampled on the bit_en that starts the slot, and neither FIFO is read.
- R5: Map code 2'b01 takes the slot's byte from FIFO A, and 2'b10 takes it from FIFO B. The block pulses the matching read strobe for exactly the one cycle whose bit_en starts the slot, and only when that FIFO is not empty. The two strobes are never high together.
- R6: If a stream's FIFO is empty when one of its slots starts, the slot carries idle_byte and that stream's underrun flag is set. The flag then stays set until reset.
- R7: frame_pulse is high exactly while bit 7 of slot 63 is on the line.
- R8: A map write (map_we, map_addr = slot number, map_data = code) changes only the shadow map. The whole shadow map becomes live on the bit_en that starts slot 0, so a write made mid-frame has no effect until the next frame.
- R9: The map supports three layouts: byte-interleaved T1, frame-interleaved T1 and alternating E1.
  - Byte-interleaved T1: each group of 8 slots is two unassigned slots, then A,B,A,B,A,B.
  - Frame-interleaved T1: slots 0-23 are A, slots 24-31 unassigned, slots 32-55 B, slots 56-63 unassigned.
  - Alternating E1: even slots are A and odd slots are B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle enable per line bit period |
| idle_byte | input | 8 | Fill value for unassigned or starved slots |
| map_we | input | 1 | Slot map write enable |
| map_addr | input | 6 | Slot number to write |
| map_data | input | 2 | Slot code: 00 idle, 01 stream A, 10 stream B, 11 idle |
| a_empty | input | 1 | FIFO A has no byte |
| a_data | input | 8 | Head byte of FIFO A |
| a_rd | output | 1 | Pop strobe for FIFO A |
| b_empty | input | 1 | FIFO B has no byte |
| b_data | input | 8 | Head byte of FIFO B |
| b_rd | output | 1 | Pop strobe for FIFO B |
| tx_bit | output | 1 | Serial backplane data |
| frame_pulse | output | 1 | Frame marker during the final bit of the frame |
| a_underrun | output | 1 | Sticky: stream A starved in one of its slots |
| b_underrun | output | 1 | Sticky: stream B starved in one of its slots |

## Verification
The assertions check, on every cycle, that:
- the two read strobes never overlap;
- a strobe only fires on a bit_en and with a byte present;
- the line holds still between enables;
- the frame pulse drops after its single bit;
- the underrun flags never clear.

Only the bench's scenarios can show the rest. That covers the serial byte content and MSB-first order in each slot, and that each layout places the right stream in the right slot. It also covers that a mid-frame map write is deferred to the next frame, and that code 11 and starved slots carry the idle byte.

// File: rtl/tdm_slot_mux.sv
module tdm_slot_mux #(
  parameter int NSLOT = 64,
  parameter int BW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bit_en,
  input  logic [BW-1:0]            idle_byte,
  input  logic                     map_we,
  input  logic [$clog2(NSLOT)-1:0] map_addr,
  input  logic [1:0]               map_data,
  input  logic                     a_empty,
  input  logic [BW-1:0]            a_data,
  output logic                     a_rd,
  input  logic                     b_empty,
  input  logic [BW-1:0]            b_data,
  output logic                     b_rd,
  output logic                     tx_bit,
  output logic                     frame_pulse,
  output logic                     a_underrun,
  output logic                     b_underrun
);
  localparam int SW = $clog2(NSLOT);
  localparam int CW = $clog2(BW);
  localparam logic [1:0] CODE_A = 2'b01;
  localparam logic [1:0] CODE_B = 2'b10;

  logic [1:0]    shadow_map [NSLOT];
  logic [1:0]    live_map   [NSLOT];
  logic [SW-1:0] slot;
  logic [CW-1:0] bitc;
  logic [BW-1:0] sh;

  wire           last_bit  = (bitc == CW'(BW-1));
  wire           wrap      = (slot == SW'(NSLOT-1));
  wire           slot_step = bit_en & last_bit;
  wire [SW-1:0]  nslot     = wrap ? '0 : slot + SW'(1);
  wire [1:0]     ncode     = wrap ? shadow_map[0] : live_map[nslot];
  wire           want_a    = slot_step & (ncode == CODE_A);
  wire           want_b    = slot_step & (ncode == CODE_B);

  assign a_rd        = want_a & ~a_empty;
  assign b_rd        = want_b & ~b_empty;
  assign tx_bit      = sh[BW-1];
  assign frame_pulse = wrap & last_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) shadow_map[i] <= 2'b00;
    end else if (map_we) begin
      shadow_map[map_addr] <= map_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) live_map[i] <= 2'b00;
    end else if (slot_step && wrap) begin
      for (int i = 0; i < NSLOT; i++) live_map[i] <= shadow_map[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot <= SW'(NSLOT-1);
      bitc <= CW'(BW-1);
      sh   <= '1;
    end else if (bit_en) begin
      if (last_bit) begin
        bitc <= '0;
        slot <= nslot;
        sh   <= a_rd ? a_data : (b_rd ? b_data : idle_byte);
      end else begin
        bitc <= bitc + CW'(1);
        sh   <= {sh[BW-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_underrun <= 1'b0;
      b_underrun <= 1'b0;
    end else begin
      if (want_a && a_empty) a_underrun <= 1'b1;
      if (want_b && b_empty) b_underrun <= 1'b1;
    end
  end
endmodule

// File: rtl/tdm_slot_mux_chk.sv
module tdm_slot_mux_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic a_empty,
  input logic b_empty,
  input logic a_rd,
  input logic b_rd,
  input logic tx_bit,
  input logic frame_pulse,
  input logic a_underrun,
  input logic b_underrun
);
  // R5
  rd_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n) !(a_rd && b_rd));
  // R5
  a_rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) a_rd |-> (bit_en && !a_empty));
  // R5
  b_rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) b_rd |-> (bit_en && !b_empty));
  // R2
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(tx_bit) && $stable(frame_pulse)));
  // R7
  pulse_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) (frame_pulse && bit_en) |=> !frame_pulse);
  // R6
  a_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) a_underrun |=> a_underrun);
  // R6
  b_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) b_underrun |=> b_underrun);
endmodule

bind tdm_slot_mux tdm_slot_mux_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .a_empty(a_empty), .b_empty(b_empty),
  .a_rd(a_rd), .b_rd(b_rd), .tx_bit(tx_bit), .frame_pulse(frame_pulse),
  .a_underrun(a_underrun), .b_underrun(b_underrun)
);

// File: tb/sim_tdm_slot_mux.sv
`timescale 1ns/1ps
module sim_tdm_slot_mux;
  logic clk = 0, rst_n = 0, bit_en = 0, map_we = 0;
  logic [7:0] idle_byte = 8'h00, a_data = 8'h00, b_data = 8'h00;
  logic [5:0] map_addr = '0;
  logic [1:0] map_data = '0;
  logic a_empty = 1, b_empty = 1;
  logic a_rd, b_rd, tx_bit, frame_pulse, a_underrun, b_underrun;

  always #2.5 clk = ~clk;

  tdm_slot_mux u0 (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  string sc = "R1 reset";
  logic [7:0] qa[$], qb[$];
  logic [1:0] m_sh[64], m_live[64];
  int ms = 63, mb = 7, kind = 0;
  logic [7:0] mbyte = 8'hFF, idle_v = 8'h00;
  bit m_ua = 0, m_ub = 0, last_en = 1;

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s]: got %0h expected %0h", msg, sc, act, exp);
    end
  endtask

  task automatic check_out();
    string base;
    base = (kind == 0) ? "R4 idle bit" : (kind == 3) ? "R6 starved idle bit" : "R3 R5 stream bit";
    if (!last_en) base = {"R2 hold ", base};
    chk(tx_bit === mbyte[7], base, tx_bit, mbyte[7]);
    chk(frame_pulse === (ms == 63 && mb == 7), "R7 frame pulse", frame_pulse, (ms == 63 && mb == 7));
    chk(a_underrun === m_ua, "R6 A underrun flag", a_underrun, m_ua);
    chk(b_underrun === m_ub, "R6 B underrun flag", b_underrun, m_ub);
  endtask

  task automatic step(input bit en);
    logic [1:0] code;
    int ns;
    bit pa, pb;
    @(negedge clk);
    check_out();
    map_we = 0;
    a_empty = (qa.size() == 0); a_data = a_empty ? 8'h00 : qa[0];
    b_empty = (qb.size() == 0); b_data = b_empty ? 8'h00 : qb[0];
    idle_byte = idle_v;
    bit_en = en;
    #1;
    pa = 0; pb = 0; code = 2'b00; ns = 0;
    if (en && mb == 7) begin
      ns = (ms == 63) ? 0 : ms + 1;
      code = (ms == 63) ? m_sh[0] : m_live[ns];
      pa = (code == 2'b01) && (qa.size() > 0);
      pb = (code == 2'b10) && (qb.size() > 0);
    end
    chk(a_rd === pa, "R5 A read strobe", a_rd, pa);
    chk(b_rd === pb, "R5 B read strobe", b_rd, pb);
    if (en) begin
      if (mb == 7) begin
        if (ms == 63) m_live = m_sh;
        if (pa) mbyte = qa.pop_front();
        else if (pb) mbyte = qb.pop_front();
        else mbyte = idle_v;
        if (code == 2'b01 && !pa) m_ua = 1;
        if (code == 2'b10 && !pb) m_ub = 1;
        kind = pa ? 1 : pb ? 2 : (code == 2'b01 || code == 2'b10) ? 3 : 0;
        mb = 0; ms = ns;
      end else begin
        mb++;
        mbyte = {mbyte[6:0], 1'b0};
      end
    end
    last_en = en;
  endtask

  task automatic run_bits(input int n);
    for (int k = 0; k < n; ) begin
      bit en;
      en = ($urandom_range(0, 3) != 0);
      step(en);
      if (en) k++;
    end
  endtask

  task automatic wr(input int addr, input logic [1:0] code);
    @(negedge clk);
    bit_en = 0;
    map_we = 1; map_addr = 6'(addr); map_data = code;
    m_sh[addr] = code;
    last_en = 0;
  endtask

  function automatic logic [1:0] layout(input int which, input int s);
    int g;
    g = s % 8;
    case (which)
      0: return (g < 2) ? 2'b00 : ((g % 2 == 0) ? 2'b01 : 2'b10);
      1: return (s < 24) ? 2'b01 : (s < 32) ? 2'b00 : (s < 56) ? 2'b10 : 2'b00;
      2: return (s % 2 == 0) ? 2'b01 : 2'b10;
      default: return 2'($urandom_range(0, 3));
    endcase
  endfunction

  task automatic load_map(input int which);
    for (int s = 0; s < 64; s++) wr(s, layout(which, s));
  endtask

  task automatic fill(input int na, input int nb);
    for (int i = 0; i < na; i++) qa.push_back(8'($urandom));
    for (int i = 0; i < nb; i++) qb.push_back(8'($urandom));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired [%s]: got %0d expected %0d", sc, 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4021));
    for (int i = 0; i < 64; i++) begin m_sh[i] = 2'b00; m_live[i] = 2'b00; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(frame_pulse === 1'b1, "R1 reset frame pulse", frame_pulse, 1);
    chk(tx_bit === 1'b1, "R1 reset line", tx_bit, 1);
    chk(a_rd === 1'b0 && b_rd === 1'b0, "R1 reset strobes", {a_rd, b_rd}, 0);
    chk(a_underrun === 1'b0 && b_underrun === 1'b0, "R1 reset flags", {a_underrun, b_underrun}, 0);

    sc = "R1 R4 default map idle";
    idle_v = 8'h5A; fill(4, 4);
    run_bits(512);
    chk(qa.size() == 4 && qb.size() == 4, "R4 no reads on idle map", qa.size() + qb.size(), 8);

    sc = "R9 byte-interleaved T1";
    load_map(0); idle_v = 8'hC3; fill(40, 40);
    run_bits(1024);

    sc = "R9 frame-interleaved T1";
    load_map(1); idle_v = 8'h81; fill(48, 48);
    run_bits(1024);

    sc = "R9 alternating E1";
    load_map(2); idle_v = 8'h7E; fill(64, 64);
    run_bits(1024);

    sc = "R8 deferred map write";
    qa.delete(); qb.delete();
    for (int s = 0; s < 64; s++) wr(s, 2'b00);
    idle_v = 8'h00;
    run_bits(512 + 100);
    qa.push_back(8'h3C);
    wr(40, 2'b01);
    run_bits(412);
    chk(qa.size() == 1, "R8 no read before boundary", qa.size(), 1);
    run_bits(512);
    chk(qa.size() == 0, "R8 read after boundary", qa.size(), 0);

    sc = "R6 starved stream B";
    qa.delete(); qb.delete();
    load_map(2); idle_v = 8'hE7; fill(64, 10);
    run_bits(1024);
    chk(b_underrun === 1'b1, "R6 B flag after starvation", b_underrun, 1);

    sc = "R4 random map with code 11";
    load_map(3); idle_v = 8'h99; fill(80, 80);
    run_bits(1024);
    idle_v = 8'h12;
    run_bits(512);

    @(negedge clk);
    check_out();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule